// File: doc/BRIEF.md
# Sectioned GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O peripheral with 32 pins. The pins are grouped into four sections of eight, and each section has its own 64-byte register window. Software uses the windows to set each pin's direction, drive output values, read the sampled pad levels and manage per-pin interrupts. All of these requests arrive over a simple synchronous register bus. Reads are combinational from the current address. A write takes effect at the clock edge where the write enable is high.

Every pad input passes through a two-flop synchronizer. Each pin can then raise an interrupt in one of two modes. In edge mode the status bit latches on a rising edge of the synchronized input. In level mode the status bit is held while the input is high. A mask can be set and cleared through separate write ports. The interrupt output is the OR of every unmasked status bit across the four sections. Reset comes in asynchronously and is released on the clock through a two-flop stage. The first register update therefore happens on the third rising edge after reset is deasserted.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe all 0), pin_out is 0, and every mask bit is 1. Raw status, masked status and the level configuration are all 0, and irq is 0.
- R2: The address is decoded as follows. bus_addr[7:6] selects the section, bus_addr[5:2] selects the word and bus_addr[1:0] is ignored. Pin n sits in section n/8 at bit n%8, so pin 10 is bit 2 of section 1.
- R3: The direction word (offset 0x10) is read/write. A bit value of 1 makes the pin an input and 0 makes it an output. pin_oe for that pin is the inverse of the direction bit.
- R4: The output word (offset 0x14) is read/write, and its bits drive pin_out for the section whatever the direction.
- R5: The input word (offset 0x18) shows pin_in after two flops, so a change on the pin is first visible after the second rising edge. Writes to this word are ignored.
- R6: A pin in edge mode sets its raw status bit (offset 0x04) on the third rising edge after pin_in rises. A falling edge sets nothing.
- R7: In the level word (offset 0x20), a 1 selects level mode. While a level-mode pin's synchronized input is high, its status bit stays set and clear writes to it have no effect. The bit stays set after the input falls, until it is cleared.
- R8: Writing 1s to offset 0x04 clears those raw status bits. If a new status event and a clear for the same bit land on the same edge, the event wins.
- R9: Writing 1s to offset 0x08 sets those mask bits, and writing 1s to offset 0x0C clears them. In both cases 0 bits leave the mask unchanged. Offset 0x08 reads the mask, and offset 0x0C reads 0.
- R10: Offset 0x00 reads raw status AND NOT mask. Writes to it are ignored.
- R11: irq is 1 exactly when some section has a status bit set whose mask bit is 0.
- R12: Read data bits 31:8 are always 0, and write data bits 31:8 are ignored. Word offsets 0x1C and 0x24 through 0x3C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
Some behaviour can be checked on every cycle. These checks cover the following:
- A direction or output write appears on pin_oe or pin_out of the addressed section one edge later.
- The upper read bits stay zero.
- The unmask word and the unused words always read zero.

The sequences that depend on history can only be shown by the bench scenarios. These are the two-edge synchronizer delay, the third-edge timing of an edge event, a level pin resisting a clear, event-over-clear priority, and the mask gating irq. A behavioural reference model checks pin_out, pin_oe and irq on every cycle. Each read is compared both with the model and with values worked out by hand.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int unsigned PINS_PER_SEC = 8;
  localparam int unsigned NUM_SEC      = 4;
  localparam int unsigned BUS_DW       = 32;
  localparam int unsigned SYNC_DEPTH   = 2;

  typedef logic [3:0] word_t;

  // Word index within a section window (byte offset / 4)
  localparam word_t WD_MSTAT = 4'h0;
  localparam word_t WD_RAW   = 4'h1;
  localparam word_t WD_MSET  = 4'h2;
  localparam word_t WD_MCLR  = 4'h3;
  localparam word_t WD_DIR   = 4'h4;
  localparam word_t WD_OUT   = 4'h5;
  localparam word_t WD_IN    = 4'h6;
  localparam word_t WD_LVL   = 4'h8;
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gsc_section.sv
module gsc_section
  import gsc_pkg::*;
#(
  parameter int unsigned W = PINS_PER_SEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         we,
  input  word_t        word,
  input  logic [W-1:0] wbyte,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] rbyte,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] mstat
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] out_d;
  logic [W-1:0] msk_q, msk_d;
  logic [W-1:0] st_q, st_d;
  logic [W-1:0] lvl_q, lvl_d;
  logic [W-1:0] prev_q;
  logic [W-1:0] set_v, clr_v;
  logic         wr;
  logic         dir_en, out_en, msk_en, lvl_en;

  assign wr = sel & we;

  // next-state logic
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    msk_d  = msk_q;
    lvl_d  = lvl_q;
    dir_en = 1'b0;
    out_en = 1'b0;
    msk_en = 1'b0;
    lvl_en = 1'b0;
    if (wr) begin
      case (word)
        WD_MSET: begin msk_d = msk_q | wbyte;  msk_en = 1'b1; end
        WD_MCLR: begin msk_d = msk_q & ~wbyte; msk_en = 1'b1; end
        WD_DIR:  begin dir_d = wbyte;          dir_en = 1'b1; end
        WD_OUT:  begin out_d = wbyte;          out_en = 1'b1; end
        WD_LVL:  begin lvl_d = wbyte;          lvl_en = 1'b1; end
        default: ;
      endcase
    end
    // event sources: rising edge for edge pins, high level for level pins
    set_v = (pin_s & ~prev_q & ~lvl_q) | (pin_s & lvl_q);
    clr_v = (wr && word == WD_RAW) ? wbyte : '0;
    st_d  = (st_q & ~clr_v) | set_v;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      msk_q  <= '1;
      lvl_q  <= '0;
      st_q   <= '0;
      prev_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (out_en) out_q <= out_d;
      if (msk_en) msk_q <= msk_d;
      if (lvl_en) lvl_q <= lvl_d;
      st_q   <= st_d;
      prev_q <= pin_s;
    end
  end

  assign oe    = ~dir_q;
  assign mstat = st_q & ~msk_q;

  // read mux
  always_comb begin
    case (word)
      WD_MSTAT: rbyte = st_q & ~msk_q;
      WD_RAW:   rbyte = st_q;
      WD_MSET:  rbyte = msk_q;
      WD_DIR:   rbyte = dir_q;
      WD_OUT:   rbyte = out_q;
      WD_IN:    rbyte = pin_s;
      WD_LVL:   rbyte = lvl_q;
      default:  rbyte = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
  import gsc_pkg::*;
#(
  parameter int unsigned SEC_W    = PINS_PER_SEC,
  parameter int unsigned SECTIONS = NUM_SEC,
  parameter int unsigned DW       = BUS_DW,
  parameter int unsigned SYNC_N   = SYNC_DEPTH,
  localparam int unsigned PINS     = SEC_W * SECTIONS,
  localparam int unsigned SEC_BITS = (SECTIONS > 1) ? $clog2(SECTIONS) : 1,
  localparam int unsigned AW       = SEC_BITS + 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  logic [1:0]          rst_sync_q;
  logic                rst_i_n;
  logic [PINS-1:0]     pin_s;
  logic [PINS-1:0]     mstat_all;
  logic [SEC_W-1:0]    rb [SECTIONS];
  logic [SEC_BITS-1:0] sec_idx;
  word_t               word;
  logic                unused_bits;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  gsc_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  assign sec_idx     = bus_addr[AW-1:6];
  assign word        = bus_addr[5:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:SEC_W]};

  for (genvar s = 0; s < int'(SECTIONS); s++) begin : g_sec
    gsc_section #(.W(SEC_W)) u_sec (
      .clk   (clk),
      .rst_n (rst_i_n),
      .sel   (sec_idx == SEC_BITS'(s)),
      .we    (bus_we),
      .word  (word),
      .wbyte (bus_wdata[SEC_W-1:0]),
      .pin_s (pin_s[s*SEC_W +: SEC_W]),
      .rbyte (rb[s]),
      .out_q (pin_out[s*SEC_W +: SEC_W]),
      .oe    (pin_oe[s*SEC_W +: SEC_W]),
      .mstat (mstat_all[s*SEC_W +: SEC_W])
    );
  end

  assign bus_rdata = {{(DW-SEC_W){1'b0}}, rb[sec_idx]};
  assign irq       = |mstat_all;
endmodule

// File: rtl/gsc_chk.sv
module gsc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe
);
  function automatic logic [7:0] sec_byte(input logic [31:0] v, input logic [1:0] s);
    return v[int'(s)*8 +: 8];
  endfunction

  logic [3:0] wd;
  assign wd = bus_addr[5:2];

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:8] == 24'h0);

  a_r9_unmask_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wd == 4'h3) |-> (bus_rdata == 32'h0));

  a_r12_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wd == 4'h7 || wd > 4'h8) |-> (bus_rdata == 32'h0));

  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wd == 4'h4) |=>
      (sec_byte(pin_oe, $past(bus_addr[7:6])) == ~$past(bus_wdata[7:0])));

  a_r4_out_to_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wd == 4'h5) |=>
      (sec_byte(pin_out, $past(bus_addr[7:6])) == $past(bus_wdata[7:0])));
endmodule

bind gpio_sect_ctrl gsc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_sect_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_sect_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;
  int wdog   = 0;

  always #2.5 clk = ~clk;

  gpio_sect_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dir, m_out, m_msk, m_st, m_lvl, m_s1, m_s2, m_prev;
  int rcnt = 0;

  always @(posedge clk) begin
    logic [31:0] ev, clr, bm;
    int sh;
    if (!rst_n) rcnt = 0;
    if (!rst_n || rcnt < 2) begin
      if (rst_n) rcnt++;
      m_dir = '1; m_out = '0; m_msk = '1; m_st = '0; m_lvl = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      sh  = int'(bus_addr[7:6]) * 8;
      bm  = 32'(bus_wdata[7:0]) << sh;
      ev  = 0;
      clr = 0;
      for (int p = 0; p < 32; p++) begin
        if (m_lvl[p]) ev[p] = m_s2[p];
        else          ev[p] = m_s2[p] && !m_prev[p];
      end
      if (bus_we && bus_addr[5:2] == 4'h1) clr = bm;
      if (bus_we) begin
        case (bus_addr[5:2])
          4'h2: m_msk = m_msk | bm;
          4'h3: m_msk = m_msk & ~bm;
          4'h4: m_dir[sh +: 8] = bus_wdata[7:0];
          4'h5: m_out[sh +: 8] = bus_wdata[7:0];
          4'h8: m_lvl[sh +: 8] = bus_wdata[7:0];
          default: ;
        endcase
      end
      m_st   = (m_st & ~clr) | ev;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int sh;
    logic [31:0] v;
    sh = int'(a[7:6]) * 8;
    case (a[5:2])
      4'h0: v = m_st & ~m_msk;
      4'h1: v = m_st;
      4'h2: v = m_msk;
      4'h4: v = m_dir;
      4'h5: v = m_out;
      4'h6: v = m_s2;
      4'h8: v = m_lvl;
      default: v = 0;
    endcase
    return 32'(v[sh +: 8]);
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk(pin_out, m_out, "R4 pin_out vs model");
      chk(pin_oe, ~m_dir, "R3 pin_oe vs model");
      chk({31'h0, irq}, {31'h0, |(m_st & ~m_msk)}, "R11 irq vs model");
    end
  end

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_we = 1'b0;
    #1;
    chk(bus_rdata, exp, tag);
    chk(bus_rdata, model_read(a), {tag, " model"});
    @(negedge clk);
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    nclk(3);
    rst_n = 1'b1;
    nclk(3);
    chk_en = 1'b1;

    // R1: reset state
    chk(pin_oe, 32'h0, "R1 oe after reset");
    chk(pin_out, 32'h0, "R1 out after reset");
    chk({31'h0, irq}, 32'h0, "R1 irq after reset");
    for (int s = 0; s < 4; s++) begin
      rd(8'(s*64 + 8'h00), 32'h00, "R1 masked status");
      rd(8'(s*64 + 8'h04), 32'h00, "R1 raw status");
      rd(8'(s*64 + 8'h08), 32'hFF, "R1 mask");
      rd(8'(s*64 + 8'h10), 32'hFF, "R1 direction");
      rd(8'(s*64 + 8'h20), 32'h00, "R1 level cfg");
    end

    // R2, R3, R4: direction and output, low address bits ignored
    wr(8'h53, 32'h0F);
    wr(8'h54, 32'hA5);
    chk(pin_oe, 32'h0000_F000, "R3 section1 oe");
    chk(pin_out, 32'h0000_A500, "R4 section1 out");
    rd(8'h50, 32'h0F, "R2 dir readback");
    wr(8'hD4, 32'hFFFF_FF3C);
    chk(pin_out, 32'h3C00_A500, "R12 upper wdata ignored on out");
    rd(8'hD4, 32'h3C, "R4 out readback");

    // R5: input view through two flops
    pin_in = 32'h5A3C_C300;
    nclk(1);
    rd(8'h98, 32'h00, "R5 not yet visible after one edge");
    rd(8'h98, 32'h3C, "R5 visible after two edges");
    rd(8'hD8, 32'h5A, "R5 section3 input");
    wr(8'h98, 32'hFF);
    rd(8'h98, 32'h3C, "R5 write ignored");
    rd(8'h5B, 32'hC3, "R5 section1 input");
    wr(8'h04, 32'hFF); wr(8'h44, 32'hFF); wr(8'h84, 32'hFF); wr(8'hC4, 32'hFF);
    rd(8'h84, 32'h00, "R8 clear all");
    pin_in = 32'h0;
    nclk(4);
    rd(8'h84, 32'h00, "R6 falling edge sets nothing");
    rd(8'hC4, 32'h00, "R6 falling edge sets nothing s3");

    // R6, R9, R10, R11: edge event on pin 10 (section 1 bit 2)
    pin_in[10] = 1'b1;
    nclk(2);
    rd(8'h44, 32'h00, "R6 not set before third edge");
    rd(8'h44, 32'h04, "R6 pin10 set on third edge");
    chk({31'h0, irq}, 32'h0, "R11 masked event gives no irq");
    wr(8'h4C, 32'h04);
    rd(8'h48, 32'hFB, "R9 unmask clears one bit");
    rd(8'h4C, 32'h00, "R9 unmask word reads zero");
    rd(8'h40, 32'h04, "R10 masked status");
    chk({31'h0, irq}, 32'h1, "R11 irq with unmasked event");
    wr(8'h40, 32'hFF);
    rd(8'h44, 32'h04, "R10 masked status write ignored");
    wr(8'h48, 32'h04);
    rd(8'h40, 32'h00, "R10 remasked");
    chk({31'h0, irq}, 32'h0, "R9 mask set drops irq");
    wr(8'h4C, 32'h04);
    chk({31'h0, irq}, 32'h1, "R9 unmask restores irq");
    wr(8'h44, 32'h04);
    chk({31'h0, irq}, 32'h0, "R8 clear drops irq");
    rd(8'h44, 32'h00, "R8 status cleared");

    // R8: event and clear on the same edge, event wins
    pin_in[0] = 1'b1;
    nclk(2);
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h01, "R8 event beats clear");
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h00, "R8 later clear works");

    // R7: level mode on pin 24 (section 3 bit 0)
    wr(8'hE0, 32'h01);
    rd(8'hE0, 32'h01, "R7 level cfg readback");
    wr(8'hCC, 32'h01);
    pin_in[24] = 1'b1;
    nclk(3);
    rd(8'hC4, 32'h01, "R7 level set");
    chk({31'h0, irq}, 32'h1, "R11 level irq");
    wr(8'hC4, 32'h01);
    rd(8'hC4, 32'h01, "R7 clear ignored while high");
    pin_in[24] = 1'b0;
    nclk(4);
    rd(8'hC4, 32'h01, "R7 held after input low");
    wr(8'hC4, 32'h01);
    rd(8'hC4, 32'h00, "R7 cleared after low");
    chk({31'h0, irq}, 32'h0, "R7 irq gone");

    // R12: unused words
    rd(8'h1C, 32'h00, "R12 word 0x1C");
    rd(8'h24, 32'h00, "R12 word 0x24");
    rd(8'hFC, 32'h00, "R12 word 0x3C");
    wr(8'h64, 32'hFF);
    wr(8'h7C, 32'hFF);
    rd(8'h50, 32'h0F, "R12 dir untouched");
    rd(8'h54, 32'hA5, "R12 out untouched");
    rd(8'h48, 32'hFB, "R12 mask untouched");

    nclk(2);
    finish_run();
  end
endmodule